// File: doc/BRIEF.md
# Block Address Translation Matcher

This block keeps two banks of block-translation register pairs, one consulted for instruction fetches and one for data accesses. Each pair maps one naturally aligned block of virtual space, 128 KB or larger, onto a physical block of the same size. A requester presents a 32-bit virtual address together with a bank select and the current privilege level. One clock later the block returns a hit flag, the index of the matching entry and the translated physical address.

Software reaches the pairs through a special-register port. A 10-bit register number is decoded into bank, entry and word. Reads are combinational. Every accepted write also raises a one-cycle flush pulse, so that downstream translation caches drop entries that may now be stale. Page-table walks, caching attributes and access protection are handled elsewhere.

Top module: `bat_xlate`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, every decoded register reads zero and `flush_o` is low.
- R2: The privilege mask is {~req_user, req_user}. A supervisor lookup (`req_user`=0) considers only entries whose upper-word bit 1 is set. A user lookup considers only entries whose upper-word bit 0 is set.
- R3: The length field is upper[12:2]. The compare mask is the 32-bit inverse of that field shifted left by 17. The effective base is upper[31:17] (low 17 bits zero). An entry matches when that base equals the virtual address ANDed with the mask.
- R4: When several entries match, the lowest index is reported.
- R5: The physical address is lower[31:17] (low 17 bits zero) plus the 4 KB-aligned virtual page minus the effective base, computed modulo 2^32. Address bits [11:0] pass through unchanged.
- R6: `req_bank`=0 searches only the instruction bank and `req_bank`=1 searches only the data bank.
- R7: A register number is accepted when num[9:5] is 5'h10 or 5'h11. Bit 3 selects the bank (0 instruction, 1 data). The entry index is num[2:1] plus 4 when num[5] is set. num[0] selects the word (0 upper, 1 lower), and num[4] is ignored. Accepted writes update that word, and reads return it.
- R8: For numbers that are not accepted, writes change no entry and raise no flush, and reads return zero.
- R9: Each accepted write makes `flush_o` high for exactly the one cycle following the write edge.
- R10: `rsp_valid` is high in the cycle after the request edge. `rsp_hit`, `rsp_index` and `rsp_paddr` reflect the registers as they stood at that edge. On a miss, or with no request, the index and address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_bank | input | 1 | 0 instruction bank, 1 data bank |
| req_user | input | 1 | 1 user level, 0 supervisor |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_hit | output | 1 | A qualified entry matched |
| rsp_index | output | 3 | Winning entry index |
| rsp_paddr | output | 32 | Translated physical address |
| spr_num | input | 10 | Special-register number |
| spr_we | input | 1 | Write strobe |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Combinational read data |
| flush_o | output | 1 | Translation-cache flush pulse |

## Verification
On every cycle the assertions check several properties. A response follows each request by one cycle. A miss carries a zero index and address. The page offset of a hit equals the requested offset. The priority grant is never more than one-hot. A flush never appears without a preceding accepted write.

Only the bench's scenarios can show the rest:
- the privilege selection between the two valid bits;
- the length-dependent mask;
- lowest-index priority among overlapping blocks;
- bank isolation;
- the register-number aliasing;
- the exact physical arithmetic.

The bench's reference model checks these every clock under both directed and pseudo-random traffic.

// File: rtl/bat_pkg.sv
package bat_pkg;
   localparam int unsigned ADDR_W   = 32;
   localparam int unsigned NUM_BANK = 2;
   localparam int unsigned SUP_BIT  = 1;
   localparam int unsigned USR_BIT  = 0;
   localparam int unsigned LEN_LSB  = 2;
   localparam int unsigned LEN_W    = 11;

   typedef struct packed {
      logic [ADDR_W-1:0] upper;
      logic [ADDR_W-1:0] lower;
   } bat_pair_t;

   // Two-bit qualifier: supervisor tests bit 1, user tests bit 0
   function automatic logic [1:0] priv_mask(input logic user);
      return {~user, user};
   endfunction
endpackage

// File: rtl/bat_entry_match.sv
module bat_entry_match import bat_pkg::*; #(
   parameter int unsigned BLOCK_SHIFT = 17,
   parameter int unsigned PAGE_SHIFT  = 12
) (
   input  bat_pair_t         pair,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [1:0]        pmask,
   output logic              match,
   output logic [ADDR_W-1:0] paddr
);
   localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << BLOCK_SHIFT;
   localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_SHIFT;

   if (LEN_LSB + LEN_W > BLOCK_SHIFT || BLOCK_SHIFT >= ADDR_W || PAGE_SHIFT >= BLOCK_SHIFT) begin : g_bad_shift
      $error("bat_entry_match: inconsistent field layout");
   end

   logic [LEN_W-1:0]  len;
   logic [ADDR_W-1:0] cmp_mask;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] delta;
   logic              qual;

   always_comb begin
      len      = pair.upper[LEN_LSB +: LEN_W];
      cmp_mask = ~{{(ADDR_W-LEN_W){1'b0}}, len} << BLOCK_SHIFT;
      base     = pair.upper & BASE_MASK;
      qual     = |(pair.upper[1:0] & pmask);
      match    = qual && (base == (vaddr & cmp_mask));
      delta    = (vaddr & PAGE_MASK) - base;
      paddr    = ((pair.lower & BASE_MASK) + delta) | (vaddr & ~PAGE_MASK);
   end
endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel #(
   parameter int unsigned N = 8,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  grant
);
   always_comb begin
      any   = 1'b0;
      idx   = '0;
      grant = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (req[i]) begin
            any   = 1'b1;
            idx   = IW'(i);
            grant = N'(1) << i;
         end
      end
   end
endmodule

// File: rtl/bat_spr_decode.sv
module bat_spr_decode #(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned SPR_W       = 10,
   localparam int unsigned IW = $clog2(NUM_ENTRIES)
) (
   input  logic [SPR_W-1:0] num,
   output logic             ok,
   output logic             bank,
   output logic [IW-1:0]    idx,
   output logic             word
);
   if (SPR_W != 10) begin : g_bad_w
      $error("bat_spr_decode: register number must be 10 bits");
   end

   logic [2:0] full_idx;
   logic       cat_ok;

   always_comb begin
      cat_ok   = (num[9:5] == 5'h10) || (num[9:5] == 5'h11);
      full_idx = {num[5], num[2:1]};
      ok       = cat_ok && (32'(full_idx) < NUM_ENTRIES);
      bank     = num[3];
      idx      = full_idx[IW-1:0];
      word     = num[0];
   end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate import bat_pkg::*; #(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned BLOCK_SHIFT = 17,
   parameter int unsigned PAGE_SHIFT  = 12,
   parameter int unsigned SPR_W       = 10,
   localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_bank,
   input  logic              req_user,
   input  logic [ADDR_W-1:0] req_vaddr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_index,
   output logic [ADDR_W-1:0] rsp_paddr,
   input  logic [SPR_W-1:0]  spr_num,
   input  logic              spr_we,
   input  logic [ADDR_W-1:0] spr_wdata,
   output logic [ADDR_W-1:0] spr_rdata,
   output logic              flush_o
);
   if (NUM_ENTRIES < 2 || NUM_ENTRIES > 8 || (NUM_ENTRIES & (NUM_ENTRIES-1)) != 0) begin : g_bad_n
      $error("bat_xlate: NUM_ENTRIES must be a power of two in 2..8");
   end

   // ---------------- register-number decode ----------------
   logic             dec_ok, dec_bank, dec_word;
   logic [IDX_W-1:0] dec_idx;

   bat_spr_decode #(.NUM_ENTRIES(NUM_ENTRIES), .SPR_W(SPR_W)) u_dec (
      .num(spr_num), .ok(dec_ok), .bank(dec_bank), .idx(dec_idx), .word(dec_word)
   );

   // ---------------- register storage ----------------
   bat_pair_t pairs [NUM_BANK][NUM_ENTRIES];

   for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
         logic [ADDR_W-1:0] up_q, lo_q;
         logic              sel;
         assign sel = spr_we && dec_ok && (dec_bank == 1'(b)) && (dec_idx == IDX_W'(e));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up_q <= '0;
               lo_q <= '0;
            end else if (sel) begin
               if (dec_word) lo_q <= spr_wdata;
               else          up_q <= spr_wdata;
            end
         end
         assign pairs[b][e].upper = up_q;
         assign pairs[b][e].lower = lo_q;
      end
   end

   always_comb begin
      spr_rdata = '0;
      if (dec_ok)
         spr_rdata = dec_word ? pairs[dec_bank][dec_idx].lower : pairs[dec_bank][dec_idx].upper;
   end

   // ---------------- lookup ----------------
   logic [1:0]             pmask;
   logic [NUM_ENTRIES-1:0] match_vec;
   logic [ADDR_W-1:0]      pa_vec [NUM_ENTRIES];
   logic                   any_hit;
   logic [IDX_W-1:0]       win_idx;
   logic [NUM_ENTRIES-1:0] grant;

   assign pmask = priv_mask(req_user);

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
      bat_pair_t cand;
      assign cand = req_bank ? pairs[1][e] : pairs[0][e];
      bat_entry_match #(.BLOCK_SHIFT(BLOCK_SHIFT), .PAGE_SHIFT(PAGE_SHIFT)) u_m (
         .pair(cand), .vaddr(req_vaddr), .pmask(pmask),
         .match(match_vec[e]), .paddr(pa_vec[e])
      );
   end

   bat_prio_sel #(.N(NUM_ENTRIES)) u_sel (
      .req(match_vec), .any(any_hit), .idx(win_idx), .grant(grant)
   );

   // ---------------- response and flush registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_index <= '0;
         rsp_paddr <= '0;
         flush_o   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any_hit;
         rsp_index <= (req_valid && any_hit) ? win_idx : '0;
         rsp_paddr <= (req_valid && any_hit) ? pa_vec[win_idx] : '0;
         flush_o   <= spr_we && dec_ok;
      end
   end

   // ---------------- assertions ----------------
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R4
   AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R10
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_paddr == '0 && rsp_index == '0)); // R10
   AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) rsp_hit |-> rsp_valid); // R10
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || rsp_paddr[PAGE_SHIFT-1:0] == $past(req_vaddr[PAGE_SHIFT-1:0]))); // R5
   AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_o) |-> $past(spr_we)); // R9
   AST_UNDECODED_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (spr_we && !dec_ok) |=> !flush_o); // R8
endmodule

// File: tb/test_bat_xlate.sv
module test_bat_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_bank = 1'b0, req_user = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid, rsp_hit, flush_o;
   logic [2:0]  rsp_index;
   logic [31:0] rsp_paddr, spr_rdata;
   logic [9:0]  spr_num = '0;
   logic        spr_we = 1'b0;
   logic [31:0] spr_wdata = '0;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   bat_xlate i_bat_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
      .req_user(req_user), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_index(rsp_index), .rsp_paddr(rsp_paddr),
      .spr_num(spr_num), .spr_we(spr_we), .spr_wdata(spr_wdata),
      .spr_rdata(spr_rdata), .flush_o(flush_o)
   );

   // ---------------- behavioural reference model ----------------
   bit [31:0] m_up [2][8];
   bit [31:0] m_lo [2][8];
   bit        e_valid, e_hit, e_flush;
   bit [2:0]  e_idx;
   bit [31:0] e_pa;
   string     e_tag = "R1";

   task automatic model_lookup(input bit bank, input bit user, input bit [31:0] va,
                               output bit hit, output bit [2:0] idx, output bit [31:0] pa);
      hit = 0; idx = 0; pa = 0;
      for (int i = 0; i < 8; i++) begin
         bit [31:0] u, bl, mask, base;
         u = m_up[bank][i];
         if (user ? !u[0] : !u[1]) continue;
         bl   = (u >> 2) & 32'h7FF;
         mask = (~bl) << 17;
         base = u & 32'hFFFE_0000;
         if (base == (va & mask)) begin
            hit = 1;
            idx = 3'(i);
            pa  = (m_lo[bank][i] & 32'hFFFE_0000) + ((va & 32'hFFFF_F000) - base) + (va & 32'hFFF);
            return;
         end
      end
   endtask

   function automatic bit num_ok(input bit [9:0] n);
      return (n >> 5) == 10'h10 || (n >> 5) == 10'h11;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++) begin m_up[b][i] = 0; m_lo[b][i] = 0; end
         e_valid = 0; e_hit = 0; e_idx = 0; e_pa = 0; e_flush = 0;
      end else begin
         e_tag   = cur_req;
         e_valid = req_valid;
         if (req_valid) model_lookup(req_bank, req_user, req_vaddr, e_hit, e_idx, e_pa);
         else begin e_hit = 0; e_idx = 0; e_pa = 0; end
         e_flush = spr_we && num_ok(spr_num);
         if (spr_we && num_ok(spr_num)) begin
            int bk, ix;
            bk = spr_num[3];
            ix = ((spr_num >> 1) & 3) + (spr_num[5] ? 4 : 0);
            if (spr_num[0]) m_lo[bk][ix] = spr_wdata;
            else            m_up[bk][ix] = spr_wdata;
         end
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison of registered outputs
   always @(negedge clk) begin
      if (rst_n) begin
         chk(e_tag, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
         chk(e_tag, "rsp_hit",   32'(rsp_hit),   32'(e_hit));
         chk(e_tag, "rsp_index", 32'(rsp_index), 32'(e_idx));
         chk(e_tag, "rsp_paddr", rsp_paddr, e_pa);
         chk("R9", "flush_o",   32'(flush_o),   32'(e_flush));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      @(negedge clk);
      req_valid = 0; spr_we = 0;
   endtask

   task automatic wr(input logic [9:0] n, input logic [31:0] d);
      @(negedge clk);
      req_valid = 0; spr_we = 1; spr_num = n; spr_wdata = d;
   endtask

   task automatic look(input logic bank, input logic user, input logic [31:0] va);
      @(negedge clk);
      spr_we = 0; req_valid = 1; req_bank = bank; req_user = user; req_vaddr = va;
   endtask

   task automatic rd(input logic [9:0] n, input logic [31:0] exp, input string tag);
      @(negedge clk);
      spr_we = 0; req_valid = 0; spr_num = n;
      #1 chk(tag, "spr_rdata", spr_rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state, empty reads and misses everywhere
      cur_req = "R1";
      @(negedge clk);
      chk("R1", "flush_o after reset", 32'(flush_o), 0);
      rd(10'h21C, 0, "R1");
      rd(10'h231, 0, "R1");
      look(0, 0, 32'h0000_0000);
      look(1, 1, 32'hFFFF_FFFF);

      // R7: data bank entry 2 (0x21C upper, 0x21D lower), supervisor-valid only
      cur_req = "R7";
      wr(10'h21C, 32'h1000_0002);
      wr(10'h21D, 32'h2000_0000);
      rd(10'h21C, 32'h1000_0002, "R7");
      rd(10'h21D, 32'h2000_0000, "R7");
      rd(10'h20C, 32'h1000_0002, "R7"); // num[4] ignored
      cur_req = "R5";
      look(1, 0, 32'h1000_5ABC);        // hit idx2 -> 0x2000_5ABC
      look(1, 0, 32'h1001_FFFF);        // last byte of 128 KB block
      cur_req = "R3";
      look(1, 0, 32'h1002_0000);        // just past the block: miss
      cur_req = "R2";
      look(1, 1, 32'h1000_5ABC);        // user level: miss
      cur_req = "R6";
      look(0, 0, 32'h1000_5ABC);        // instruction bank: miss

      // R3: entry 5 of data bank (0x23A/0x23B), 256 MB length, user-valid only
      cur_req = "R3";
      wr(10'h23A, 32'h3000_0000 | (32'h7FF << 2) | 32'h1);
      wr(10'h23B, 32'h4000_0000);
      rd(10'h23A, 32'h3000_1FFD, "R7");
      look(1, 1, 32'h3ABC_D123);        // -> 0x4ABC_D123
      cur_req = "R2";
      look(1, 0, 32'h3ABC_D123);        // supervisor: miss

      // R4: instruction entries 1 (0x212) and 6 (0x234) overlap
      cur_req = "R4";
      wr(10'h212, 32'h5000_000F);
      wr(10'h213, 32'h6000_0000);
      wr(10'h234, 32'h5000_000F);
      wr(10'h235, 32'h7000_0000);
      look(0, 0, 32'h5004_0444);        // entry 1 wins
      look(0, 1, 32'h5007_FFF0);
      wr(10'h212, 32'h0);               // retire entry 1
      look(0, 0, 32'h5004_0444);        // entry 6 now
      look(0, 0, 32'h5008_0000);        // outside 512 KB: miss

      // R8: unaccepted numbers leave state and flush untouched and read zero
      cur_req = "R8";
      wr(10'h1F4, 32'hDEAD_BEEF);
      wr(10'h24C, 32'hDEAD_BEEF);
      wr(10'h3FF, 32'hDEAD_BEEF);
      rd(10'h1F4, 0, "R8");
      rd(10'h24C, 0, "R8");
      rd(10'h234, 32'h5000_000F, "R8");
      look(0, 0, 32'h5004_0444);

      // R9: back-to-back writes give back-to-back flushes
      cur_req = "R9";
      wr(10'h214, 32'h0);
      wr(10'h215, 32'h0);
      idle();
      idle();

      // R10: pseudo-random traffic mixing lookups and writes
      cur_req = "R10";
      lf = 32'hACE1_1234;
      for (int k = 0; k < 3000; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         if (lf[3:0] == 4'h0) begin
            logic [9:0] n;
            n = {4'b1000, lf[9:4]};
            if (lf[10]) n = lf[29:20];
            wr(n, {lf[24:11], lf[31:25], lf[10:0]});
         end else if (lf[3:0] == 4'h1) begin
            idle();
         end else begin
            logic [31:0] va;
            va = {lf[7:4] & 4'h7, lf[27:0]} ^ {lf[31:28], 28'h0};
            look(lf[8], lf[9], va);
         end
      end
      idle();
      idle();

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule